// File: doc/BRIEF.md
# Priority-Arbitrated Bus Crossbar

This block joins a set of bus masters to a set of slave ports (one to sixteen) using Wishbone-style signalling: cycle, strobe, write enable, byte select, address and write data run toward the slave. Read data, acknowledge, retry and error run back toward the master. A master chooses its target slave with the upper four bits of its address. Each slave port has its own small arbiter. When the port is free, the arbiter grants the port to one of the masters that currently target it. That grant stays in place until the slave ends the transfer, and while it holds, every signal is routed straight between the pair.

Contention is settled by a priority register that software writes. It holds a two-bit level for each master. The highest level wins, and among equal levels the lowest master number wins. Each slave arbiter is a two-state machine:
- `ARB_IDLE`: the port is free.
- `ARB_OWNED`: the port is connected to one master.

It has these transitions:
- GRANT: `ARB_IDLE` to `ARB_OWNED`, when at least one eligible request is present.
- WAIT: stays in `ARB_IDLE` when there is no eligible request.
- HOLD: stays in `ARB_OWNED` while the transfer runs.
- FINISH: `ARB_OWNED` to `ARB_IDLE` when the slave returns acknowledge, retry or error.
- ABANDON: `ARB_OWNED` to `ARB_IDLE` when the owning master drops its cycle signal.

Top module: `xbar_prio_top`

## Requirements
- R1: Address bits [AW-1:AW-4] of a master give the index of its target slave. A value of NS or above targets no slave, and that master is never connected.
- R2: The priority register resets to all zeros. On a clock edge with `cfg_we_i` high it loads `cfg_prio_i`. The level of master k is bits [2k+1:2k].
- R3: When several masters request the same idle slave in one cycle, the master with the highest level is connected.
- R4: When the highest level is shared by several requesters, the lowest-numbered of them is connected.
- R5: A grant takes effect on the clock edge after the request is seen on an idle port. It does not change while the transfer runs.
- R6: While connected, the slave port carries the owner's cycle, strobe, write enable, select, address and write data.
- R7: While connected, the owning master receives the slave's read data, acknowledge, retry and error.
- R8: The cycle in which the slave returns acknowledge, retry or error is the last cycle of the connection. The same holds for the cycle in which the owner drops its cycle signal. The port is free from the next edge.
- R9: A slave port with no owner drives zero on all of its outputs. This includes the time during reset.
- R10: A master with no connection sees zero on its read data, acknowledge, retry and error.
- R11: A master that already holds one slave is not granted another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load enable for the priority register |
| cfg_prio_i | input | 2*NM | New priority levels, two bits per master |
| m_cyc_i | input | NM | Master cycle requests |
| m_stb_i | input | NM | Master strobes |
| m_we_i | input | NM | Master write enables |
| m_sel_i | input | NM*DW/8 | Master byte selects |
| m_adr_i | input | NM*AW | Master addresses |
| m_dat_i | input | NM*DW | Master write data |
| m_dat_o | output | NM*DW | Read data returned to masters |
| m_ack_o | output | NM | Acknowledge returned to masters |
| m_rty_o | output | NM | Retry returned to masters |
| m_err_o | output | NM | Error returned to masters |
| s_cyc_o | output | NS | Cycle toward slaves |
| s_stb_o | output | NS | Strobe toward slaves |
| s_we_o | output | NS | Write enable toward slaves |
| s_sel_o | output | NS*DW/8 | Byte select toward slaves |
| s_adr_o | output | NS*AW | Address toward slaves |
| s_dat_o | output | NS*DW | Write data toward slaves |
| s_dat_i | input | NS*DW | Slave read data |
| s_ack_i | input | NS | Slave acknowledge |
| s_rty_i | input | NS | Slave retry |
| s_err_i | input | NS | Slave error |

## Verification
The bench drives two masters at equal level onto one slave. An arbiter that searched from the top index, or that rotated, would connect the wrong master. It then sets unequal levels, including one placed only in bits [3:2]. A shifted field decode would hand the port to the lower level. It holds a transfer open across many cycles while responses and master drop-outs arrive at random. An arbiter that re-arbitrated mid-transfer, or that missed retry, error or an abandoned cycle as an end condition, would strand or steal a port. Finally, it aims a master at a nibble beyond the slave count and checks that no port wakes. It also checks that idle ports and unconnected masters stay at zero.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int NIB_W = 4;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/xbar_prio_reg.sv
module xbar_prio_reg #(
    parameter int NM = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic [2*NM-1:0] cfg_prio_i,
    output logic [2*NM-1:0] prio_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (cfg_we_i) begin
            prio_q <= cfg_prio_i;
        end
    end
endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb
    import xbar_pkg::*;
#(
    parameter int NM     = 4,
    parameter int SLV_ID = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NM-1:0]       m_cyc_i,
    input  logic [NM*NIB_W-1:0] m_nib_i,
    input  logic [2*NM-1:0]     prio_i,
    input  logic [NM-1:0]       busy_i,
    input  logic                end_i,
    output logic [NM-1:0]       gnt_o
);
    localparam int MIW = (NM > 1) ? $clog2(NM) : 1;
    localparam logic [NIB_W-1:0] MY_NIB = NIB_W'(SLV_ID);

    arb_state_e     state_q, state_d;
    logic [MIW-1:0] owner_q, owner_d;
    logic [NM-1:0]  req;
    logic           win_vld;
    logic [MIW-1:0] win_idx;
    logic [1:0]     win_lvl;

    // eligible requests: targets this port and is not held elsewhere
    always_comb begin
        for (int m = 0; m < NM; m++) begin
            req[m] = m_cyc_i[m] && (m_nib_i[m*NIB_W +: NIB_W] == MY_NIB) && !busy_i[m];
        end
    end

    // strict greater-than keeps the lowest index among equal levels
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int m = 0; m < NM; m++) begin
            if (req[m] && (!win_vld || (prio_i[2*m +: 2] > win_lvl))) begin
                win_vld = 1'b1;
                win_idx = MIW'(m);
                win_lvl = prio_i[2*m +: 2];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (win_vld) begin
                    state_d = ARB_OWNED;
                    owner_d = win_idx;
                end
            end
            ARB_OWNED: begin
                if (end_i || !m_cyc_i[owner_q]) begin
                    state_d = ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        gnt_o = '0;
        if (state_q == ARB_OWNED) begin
            gnt_o[owner_q] = 1'b1;
        end
    end
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
    parameter int NM = 4,
    parameter int NS = 4,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 4
) (
    input  logic [NS*NM-1:0] gnt_i,
    input  logic [NM-1:0]    m_cyc_i,
    input  logic [NM-1:0]    m_stb_i,
    input  logic [NM-1:0]    m_we_i,
    input  logic [NM*SW-1:0] m_sel_i,
    input  logic [NM*AW-1:0] m_adr_i,
    input  logic [NM*DW-1:0] m_dat_i,
    output logic [NM*DW-1:0] m_dat_o,
    output logic [NM-1:0]    m_ack_o,
    output logic [NM-1:0]    m_rty_o,
    output logic [NM-1:0]    m_err_o,
    output logic [NS-1:0]    s_cyc_o,
    output logic [NS-1:0]    s_stb_o,
    output logic [NS-1:0]    s_we_o,
    output logic [NS*SW-1:0] s_sel_o,
    output logic [NS*AW-1:0] s_adr_o,
    output logic [NS*DW-1:0] s_dat_o,
    input  logic [NS*DW-1:0] s_dat_i,
    input  logic [NS-1:0]    s_ack_i,
    input  logic [NS-1:0]    s_rty_i,
    input  logic [NS-1:0]    s_err_i
);
    // AND-OR fabric: grants are one-hot per row and per column
    always_comb begin
        m_dat_o = '0;
        m_ack_o = '0;
        m_rty_o = '0;
        m_err_o = '0;
        s_cyc_o = '0;
        s_stb_o = '0;
        s_we_o  = '0;
        s_sel_o = '0;
        s_adr_o = '0;
        s_dat_o = '0;
        for (int s = 0; s < NS; s++) begin
            for (int m = 0; m < NM; m++) begin
                if (gnt_i[s*NM + m]) begin
                    s_cyc_o[s]           |= m_cyc_i[m];
                    s_stb_o[s]           |= m_stb_i[m];
                    s_we_o[s]            |= m_we_i[m];
                    s_sel_o[s*SW +: SW]  |= m_sel_i[m*SW +: SW];
                    s_adr_o[s*AW +: AW]  |= m_adr_i[m*AW +: AW];
                    s_dat_o[s*DW +: DW]  |= m_dat_i[m*DW +: DW];
                    m_dat_o[m*DW +: DW]  |= s_dat_i[s*DW +: DW];
                    m_ack_o[m]           |= s_ack_i[s];
                    m_rty_o[m]           |= s_rty_i[s];
                    m_err_o[m]           |= s_err_i[s];
                end
            end
        end
    end
endmodule

// File: rtl/xbar_prio_top.sv
module xbar_prio_top
    import xbar_pkg::*;
#(
    parameter  int NM = 4,
    parameter  int NS = 4,
    parameter  int AW = 32,
    parameter  int DW = 32,
    localparam int SW = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic [2*NM-1:0] cfg_prio_i,
    input  logic [NM-1:0]    m_cyc_i,
    input  logic [NM-1:0]    m_stb_i,
    input  logic [NM-1:0]    m_we_i,
    input  logic [NM*SW-1:0] m_sel_i,
    input  logic [NM*AW-1:0] m_adr_i,
    input  logic [NM*DW-1:0] m_dat_i,
    output logic [NM*DW-1:0] m_dat_o,
    output logic [NM-1:0]    m_ack_o,
    output logic [NM-1:0]    m_rty_o,
    output logic [NM-1:0]    m_err_o,
    output logic [NS-1:0]    s_cyc_o,
    output logic [NS-1:0]    s_stb_o,
    output logic [NS-1:0]    s_we_o,
    output logic [NS*SW-1:0] s_sel_o,
    output logic [NS*AW-1:0] s_adr_o,
    output logic [NS*DW-1:0] s_dat_o,
    input  logic [NS*DW-1:0] s_dat_i,
    input  logic [NS-1:0]    s_ack_i,
    input  logic [NS-1:0]    s_rty_i,
    input  logic [NS-1:0]    s_err_i
);
    logic [2*NM-1:0]     prio_q;
    logic [NM*NIB_W-1:0] m_nib;
    logic [NS*NM-1:0]    gnt_flat;
    logic [NM-1:0]       busy;
    logic [NS-1:0]       end_evt;

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_nib[m*NIB_W +: NIB_W] = m_adr_i[m*AW + AW - NIB_W +: NIB_W];
        end
    end

    always_comb begin
        busy = '0;
        for (int s = 0; s < NS; s++) begin
            busy |= gnt_flat[s*NM +: NM];
        end
    end

    assign end_evt = s_ack_i | s_rty_i | s_err_i;

    xbar_prio_reg #(.NM(NM)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_prio_i (cfg_prio_i),
        .prio_q     (prio_q)
    );

    for (genvar s = 0; s < NS; s++) begin : g_arb
        xbar_slave_arb #(.NM(NM), .SLV_ID(s)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .m_cyc_i (m_cyc_i),
            .m_nib_i (m_nib),
            .prio_i  (prio_q),
            .busy_i  (busy),
            .end_i   (end_evt[s]),
            .gnt_o   (gnt_flat[s*NM +: NM])
        );
    end

    xbar_route #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .SW(SW)) u_route (
        .gnt_i   (gnt_flat),
        .m_cyc_i (m_cyc_i),
        .m_stb_i (m_stb_i),
        .m_we_i  (m_we_i),
        .m_sel_i (m_sel_i),
        .m_adr_i (m_adr_i),
        .m_dat_i (m_dat_i),
        .m_dat_o (m_dat_o),
        .m_ack_o (m_ack_o),
        .m_rty_o (m_rty_o),
        .m_err_o (m_err_o),
        .s_cyc_o (s_cyc_o),
        .s_stb_o (s_stb_o),
        .s_we_o  (s_we_o),
        .s_sel_o (s_sel_o),
        .s_adr_o (s_adr_o),
        .s_dat_o (s_dat_o),
        .s_dat_i (s_dat_i),
        .s_ack_i (s_ack_i),
        .s_rty_i (s_rty_i),
        .s_err_i (s_err_i)
    );
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
    parameter int NM = 4,
    parameter int NS = 4,
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NS*NM-1:0] gnt_flat,
    input logic [NM-1:0]    m_cyc_i,
    input logic [NM*4-1:0]  m_nib,
    input logic [NM-1:0]    m_ack_o,
    input logic [NM-1:0]    m_rty_o,
    input logic [NM-1:0]    m_err_o,
    input logic [NM*DW-1:0] m_dat_o,
    input logic [NS-1:0]    s_cyc_o,
    input logic [NS-1:0]    s_stb_o,
    input logic [NS-1:0]    s_ack_i,
    input logic [NS-1:0]    s_rty_i,
    input logic [NS-1:0]    s_err_i,
    input logic [2*NM-1:0]  prio_q
);
    // R2
    prio_reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> (prio_q == '0));

    for (genvar s = 0; s < NS; s++) begin : g_slv
        logic owned;
        logic fin;
        assign owned = |gnt_flat[s*NM +: NM];
        assign fin   = s_ack_i[s] | s_rty_i[s] | s_err_i[s];

        // R8
        release_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (owned && fin) |=> !owned);

        // R9
        idle_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !owned |-> (!s_cyc_o[s] && !s_stb_o[s]));

        for (genvar m = 0; m < NM; m++) begin : g_mst
            // R5
            hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_flat[s*NM + m] && !fin && m_cyc_i[m]) |=> gnt_flat[s*NM + m]);

            // R1
            grant_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gnt_flat[s*NM + m]) |-> $past(m_cyc_i[m] && (m_nib[m*4 +: 4] == 4'(s))));
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_col
        logic [NS-1:0] col;
        always_comb begin
            for (int s = 0; s < NS; s++) begin
                col[s] = gnt_flat[s*NM + m];
            end
        end

        // R11
        single_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));

        // R10
        orphan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (col == '0) |-> (!m_ack_o[m] && !m_rty_o[m] && !m_err_o[m] && (m_dat_o[m*DW +: DW] == '0)));
    end
endmodule

bind xbar_prio_top xbar_chk #(.NM(NM), .NS(NS), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt_flat (gnt_flat),
    .m_cyc_i  (m_cyc_i),
    .m_nib    (m_nib),
    .m_ack_o  (m_ack_o),
    .m_rty_o  (m_rty_o),
    .m_err_o  (m_err_o),
    .m_dat_o  (m_dat_o),
    .s_cyc_o  (s_cyc_o),
    .s_stb_o  (s_stb_o),
    .s_ack_i  (s_ack_i),
    .s_rty_i  (s_rty_i),
    .s_err_i  (s_err_i),
    .prio_q   (prio_q)
);

// File: tb/xbar_prio_top_tb_top.sv
module xbar_prio_top_tb_top;
    localparam int  NM = 4;
    localparam int  NS = 4;
    localparam int  AW = 32;
    localparam int  DW = 32;
    localparam int  SW = DW / 8;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int ntot = 0;
    int nbad = 0;

    // bench-side stimulus
    logic          bm_cyc [NM];
    logic          bm_stb [NM];
    logic          bm_we  [NM];
    logic [SW-1:0] bm_sel [NM];
    logic [AW-1:0] bm_adr [NM];
    logic [DW-1:0] bm_dat [NM];
    logic          bs_ack [NS];
    logic          bs_rty [NS];
    logic          bs_err [NS];
    logic [DW-1:0] bs_dat [NS];
    logic            cfg_we;
    logic [2*NM-1:0] cfg_prio;

    // reference model state
    int       own  [NS];
    logic [1:0] mpr [NM];
    bit       done [NM];

    logic [NM-1:0]    m_cyc, m_stb, m_we;
    logic [NM*SW-1:0] m_sel;
    logic [NM*AW-1:0] m_adr;
    logic [NM*DW-1:0] m_dat;
    logic [NM*DW-1:0] m_dat_o;
    logic [NM-1:0]    m_ack_o, m_rty_o, m_err_o;
    logic [NS-1:0]    s_cyc_o, s_stb_o, s_we_o;
    logic [NS*SW-1:0] s_sel_o;
    logic [NS*AW-1:0] s_adr_o;
    logic [NS*DW-1:0] s_dat_o;
    logic [NS*DW-1:0] s_dat;
    logic [NS-1:0]    s_ack, s_rty, s_err;

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_cyc[m] = bm_cyc[m];
            m_stb[m] = bm_stb[m];
            m_we[m]  = bm_we[m];
            m_sel[m*SW +: SW] = bm_sel[m];
            m_adr[m*AW +: AW] = bm_adr[m];
            m_dat[m*DW +: DW] = bm_dat[m];
        end
        for (int s = 0; s < NS; s++) begin
            s_ack[s] = bs_ack[s];
            s_rty[s] = bs_rty[s];
            s_err[s] = bs_err[s];
            s_dat[s*DW +: DW] = bs_dat[s];
        end
    end

    xbar_prio_top #(.NM(NM), .NS(NS), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_prio_i(cfg_prio),
        .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_sel_i(m_sel),
        .m_adr_i(m_adr), .m_dat_i(m_dat), .m_dat_o(m_dat_o), .m_ack_o(m_ack_o),
        .m_rty_o(m_rty_o), .m_err_o(m_err_o), .s_cyc_o(s_cyc_o), .s_stb_o(s_stb_o),
        .s_we_o(s_we_o), .s_sel_o(s_sel_o), .s_adr_o(s_adr_o), .s_dat_o(s_dat_o),
        .s_dat_i(s_dat), .s_ack_i(s_ack), .s_rty_i(s_rty), .s_err_i(s_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int owner_of(int m);
        for (int s = 0; s < NS; s++) if (own[s] == m) return s;
        return -1;
    endfunction

    // R1 R3 R4 R11 reference arbitration
    function automatic int pick(int s);
        int best = -1;
        logic [1:0] bl = 2'd0;
        for (int m = 0; m < NM; m++) begin
            if (bm_cyc[m] && bm_adr[m][AW-1 -: 4] == 4'(s) && owner_of(m) < 0 &&
                (best < 0 || mpr[m] > bl)) begin
                best = m;
                bl = mpr[m];
            end
        end
        return best;
    endfunction

    task automatic check_ports();
        for (int s = 0; s < NS; s++) begin
            int o = own[s];
            if (o >= 0) begin
                chk("R6 s_cyc", 64'(s_cyc_o[s]), 64'(bm_cyc[o]));
                chk("R6 s_stb", 64'(s_stb_o[s]), 64'(bm_stb[o]));
                chk("R6 s_we", 64'(s_we_o[s]), 64'(bm_we[o]));
                chk("R6 s_sel", 64'(s_sel_o[s*SW +: SW]), 64'(bm_sel[o]));
                chk("R6 s_adr", 64'(s_adr_o[s*AW +: AW]), 64'(bm_adr[o]));
                chk("R6 s_dat", 64'(s_dat_o[s*DW +: DW]), 64'(bm_dat[o]));
            end else begin
                chk("R9 idle port ctl", 64'({s_cyc_o[s], s_stb_o[s], s_we_o[s]}), 64'(0));
                chk("R9 idle port sel", 64'(s_sel_o[s*SW +: SW]), 64'(0));
                chk("R9 idle port adr", 64'(s_adr_o[s*AW +: AW]), 64'(0));
                chk("R9 idle port dat", 64'(s_dat_o[s*DW +: DW]), 64'(0));
            end
        end
        for (int m = 0; m < NM; m++) begin
            int s = owner_of(m);
            if (s >= 0) begin
                chk("R7 m_resp", 64'({m_ack_o[m], m_rty_o[m], m_err_o[m]}),
                    64'({bs_ack[s], bs_rty[s], bs_err[s]}));
                chk("R7 m_dat", 64'(m_dat_o[m*DW +: DW]), 64'(bs_dat[s]));
            end else begin
                chk("R10 orphan resp", 64'({m_ack_o[m], m_rty_o[m], m_err_o[m]}), 64'(0));
                chk("R10 orphan dat", 64'(m_dat_o[m*DW +: DW]), 64'(0));
            end
        end
    endtask

    // one cycle: check, advance model (R5 R8), then cross the edge
    task automatic step();
        int nxt [NS];
        #1;
        check_ports();
        for (int s = 0; s < NS; s++) begin
            int o = own[s];
            if (o >= 0) begin
                if (bs_ack[s] || bs_rty[s] || bs_err[s]) begin
                    done[o] = 1'b1;
                    nxt[s] = -1;
                end else if (!bm_cyc[o]) begin
                    nxt[s] = -1;
                end else begin
                    nxt[s] = o;
                end
            end else begin
                nxt[s] = pick(s);
            end
        end
        if (cfg_we) for (int m = 0; m < NM; m++) mpr[m] = cfg_prio[2*m +: 2];
        @(posedge clk);
        for (int s = 0; s < NS; s++) own[s] = nxt[s];
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int m = 0; m < NM; m++) begin
            bm_cyc[m] = 1'b0; bm_stb[m] = 1'b0; bm_we[m] = 1'b0;
            bm_sel[m] = '0; bm_adr[m] = '0; bm_dat[m] = '0; done[m] = 1'b0;
        end
        for (int s = 0; s < NS; s++) begin
            bs_ack[s] = 1'b0; bs_rty[s] = 1'b0; bs_err[s] = 1'b0;
            bs_dat[s] = DW'($urandom);
        end
        cfg_we = 1'b0;
        cfg_prio = '0;
    endtask

    task automatic start_req(int m, int nib);
        bm_cyc[m] = 1'b1;
        bm_stb[m] = 1'b1;
        bm_we[m]  = 1'($urandom);
        bm_sel[m] = SW'($urandom);
        bm_adr[m] = {4'(nib), (AW-4)'($urandom)};
        bm_dat[m] = DW'($urandom);
    endtask

    task automatic settle_idle();
        clear_all();
        step();
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < NS; s++) own[s] = -1;
        for (int m = 0; m < NM; m++) mpr[m] = 2'd0;
        clear_all();
        // requests during reset must not wake anything
        start_req(0, 0);
        start_req(1, 1);
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset slave cyc", 64'(s_cyc_o), 64'(0));
        chk("R10 reset master ack", 64'(m_ack_o), 64'(0));
        clear_all();
        rst_n = 1'b1;
        step();

        // R4 tie at reset level (R2 reset zero): masters 1 and 3 on slave 2
        start_req(1, 2);
        start_req(3, 2);
        step();
        #1;
        chk("R4 tie lowest index wins", 64'(s_adr_o[2*AW +: AW]), 64'(bm_adr[1]));
        bs_ack[2] = 1'b1;
        step();
        bs_ack[2] = 1'b0;
        bm_cyc[1] = 1'b0;
        step();
        step();
        #1;
        chk("R4 loser served next", 64'(s_adr_o[2*AW +: AW]), 64'(bm_adr[3]));
        bs_rty[2] = 1'b1;
        step();
        settle_idle();

        // R3 priority: master 3 level 3, master 0 level 1
        cfg_we = 1'b1;
        cfg_prio = 8'b11_00_00_01;
        step();
        cfg_we = 1'b0;
        start_req(0, 0);
        start_req(3, 0);
        step();
        #1;
        chk("R3 higher level wins", 64'(s_adr_o[0 +: AW]), 64'(bm_adr[3]));
        bs_err[0] = 1'b1;
        step();
        bs_err[0] = 1'b0;
        bm_cyc[3] = 1'b0;
        step();
        step();
        #1;
        chk("R3 lower level after", 64'(s_adr_o[0 +: AW]), 64'(bm_adr[0]));
        bs_ack[0] = 1'b1;
        step();
        settle_idle();

        // R2 field of master 1 at bits [3:2]
        cfg_we = 1'b1;
        cfg_prio = 8'b00_00_10_00;
        step();
        cfg_we = 1'b0;
        start_req(0, 1);
        start_req(1, 1);
        step();
        #1;
        chk("R2 field [3:2] for master 1", 64'(s_adr_o[1*AW +: AW]), 64'(bm_adr[1]));
        bs_ack[1] = 1'b1;
        step();
        settle_idle();

        // R1 nibble beyond NS reaches no port
        start_req(2, 4'hF);
        step();
        step();
        step();
        #1;
        chk("R1 out-of-range nibble", 64'(s_cyc_o), 64'(0));
        settle_idle();

        // R8 abandon: owner drops cycle, port frees
        start_req(0, 3);
        step();
        #1;
        chk("R5 granted after one edge", 64'(s_cyc_o[3]), 64'(1));
        step();
        bm_cyc[0] = 1'b0;
        step();
        step();
        #1;
        chk("R8 abandon frees port", 64'(s_adr_o[3*AW +: AW]), 64'(0));
        settle_idle();

        // R11 with R5: master 2 holds slave 0, then retargets slave 1 mid-transfer
        start_req(2, 0);
        step();
        bm_adr[2] = {4'd1, (AW-4)'($urandom)};
        step();
        #1;
        chk("R11 no second grant", 64'(s_cyc_o[1]), 64'(0));
        bs_ack[0] = 1'b1;
        step();
        settle_idle();

        // constrained random traffic
        for (int cyc = 0; cyc < 3000; cyc++) begin
            for (int s = 0; s < NS; s++) begin
                int r = int'($urandom % 8);
                bs_ack[s] = 1'b0; bs_rty[s] = 1'b0; bs_err[s] = 1'b0;
                bs_dat[s] = DW'($urandom);
                if (own[s] >= 0) begin
                    if (r < 3) bs_ack[s] = 1'b1;
                    else if (r == 3) bs_rty[s] = 1'b1;
                    else if (r == 4) bs_err[s] = 1'b1;
                end
            end
            for (int m = 0; m < NM; m++) begin
                if (done[m]) begin
                    bm_cyc[m] = 1'b0;
                    bm_stb[m] = 1'b0;
                    done[m] = 1'b0;
                end else if (bm_cyc[m]) begin
                    if (owner_of(m) >= 0 ? ($urandom % 40 == 0) : ($urandom % 20 == 0)) begin
                        bm_cyc[m] = 1'b0;
                        bm_stb[m] = 1'b0;
                    end else begin
                        bm_stb[m] = ($urandom % 8 != 0);
                    end
                end else if ($urandom % 3 == 0) begin
                    start_req(m, ($urandom % 16 == 0) ? int'(4'hE) : int'($urandom % NS));
                end
            end
            cfg_we = ($urandom % 30 == 0);
            cfg_prio = (2*NM)'($urandom);
            step();
        end

        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule